// File: doc/BRIEF.md
# Widening Unsigned Multiply-Subtract Vector Unit

This datapath unit runs one vector instruction: a widening unsigned multiply that is subtracted from an accumulator. It takes a 32-bit instruction word, two packed source vectors and one packed accumulator vector, each `VL` bits wide. The instruction word is decoded to confirm the opcode and to choose the lane width. Each wide accumulator lane then loses the product of the low (even-numbered) narrow element of both sources that share its bit range. Odd-numbered narrow elements never take part.

Results come back through a valid/ready pair. The latency is fixed and does not depend on the data. An instruction word with a bad opcode or the reserved size code still produces a response after the same latency. That response raises an undefined flag and returns the accumulator unchanged. Register selection, predication and writeback belong to the surrounding pipeline. The unit only carries the index fields of the instruction word and does not act on them.

Top module: `wvms_unit`

## Requirements
- R1: An instruction word is legal only when bits 31:24 are 8'b01000100, bit 21 is 0 and bits 15:10 are 6'b010110. Any mismatch in these bits gives a response with `out_undef` = 1 and `out_acc` equal to the accepted accumulator.
- R2: The size field in bits 23:22 selects the wide lane width W = 8 << size: 2'b01 gives 16-bit lanes from 8-bit elements, 2'b10 gives 32-bit lanes from 16-bit elements, and 2'b11 gives 64-bit lanes from 32-bit elements. All VL/W lanes are written.
- R3: Size 2'b00 is reserved. It gives `out_undef` = 1 and an `out_acc` identical to the accepted accumulator.
- R4: Wide lane e reads narrow element 2e of each source, which is bits [e*W +: W/2], as an unsigned value. The odd narrow elements have no effect on the result.
- R5: Lane e of the result equals the accumulator lane minus the product, taken modulo 2^W. There is no saturation and no flag. A legal instruction gives `out_undef` = 0.
- R6: When `out_ready` stays high, an input accepted in cycle c (with `in_valid` and `in_ready` both high) appears with `out_valid` high in cycle c+2. This holds for every operand value, and no response appears without an accepted input.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_acc` and `out_undef` keep their values.
- R8: `in_ready` is high whenever the output is empty or is being taken. This gives one accepted input per cycle when there is no backpressure.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.
- R10: The register index fields (bits 20:16, 9:5 and 4:0) do not affect the result or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | VL | First source vector |
| src_b | input | VL | Second source vector |
| acc_in | input | VL | Accumulator vector |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_acc | output | VL | Updated accumulator |
| out_undef | output | 1 | Instruction word not executable |

## Verification
The bench builds the unit with VL = 128, which gives 8, 4 and 2 lanes for the three legal sizes. With this width, the 64-bit lane case and the odd-element masking at every width are checked against a per-lane reference model. The width is small enough that all-ones operands show the wrap-around at every lane boundary. The bench also runs phases with steady readiness and phases with random backpressure and input gaps. These phases separate the fixed-latency property from the ordering and hold behaviour under stall.

// File: rtl/wvms_pkg.sv
`timescale 1ns/1ps
package wvms_pkg;

   typedef enum logic [1:0] {
      SZ_RSVD = 2'b00,
      SZ_H    = 2'b01,
      SZ_S    = 2'b10,
      SZ_D    = 2'b11
   } wsize_e;

   localparam logic [7:0] OPC_TOP = 8'b0100_0100;
   localparam logic [5:0] OPC_MID = 6'b010110;

   // number of legal lane widths: 16, 32, 64
   localparam int NUM_WIDTHS = 3;
   localparam int MIN_WIDE   = 16;
   localparam int MAX_WIDE   = MIN_WIDE << (NUM_WIDTHS - 1);

   typedef struct packed {
      logic   undef;
      wsize_e size;
   } dec_t;

endpackage

// File: rtl/wvms_decode.sv
`timescale 1ns/1ps
module wvms_decode
   import wvms_pkg::*;
(
   input  logic [31:0] insn,
   output dec_t        dec
);

   logic   opc_ok;
   wsize_e sz;

   always_comb begin
      opc_ok = (insn[31:24] == OPC_TOP) &&
               (insn[21] == 1'b0) &&
               (insn[15:10] == OPC_MID);
      sz        = wsize_e'(insn[23:22]);
      dec.size  = sz;
      dec.undef = !opc_ok || (sz == SZ_RSVD);
   end

   // register index fields travel with the operation but are not used here
   logic unused_idx;
   assign unused_idx = ^{insn[20:16], insn[9:0]};

endmodule

// File: rtl/wvms_prod_gen.sv
`timescale 1ns/1ps
module wvms_prod_gen
   import wvms_pkg::*;
#(
   parameter int VL = 128
) (
   input  logic [VL-1:0] src_a,
   input  logic [VL-1:0] src_b,
   input  wsize_e        size,
   output logic [VL-1:0] prod
);

   for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_w
      localparam int W = MIN_WIDE << k;
      localparam int H = W / 2;
      localparam int N = VL / W;
      logic [VL-1:0] p;
      for (genvar ln = 0; ln < N; ln++) begin : g_lane
         logic [H-1:0] ea;
         logic [H-1:0] eb;
         assign ea = src_a[ln*W +: H];
         assign eb = src_b[ln*W +: H];
         // full product of two H-bit values fits W bits exactly
         assign p[ln*W +: W] = {{H{1'b0}}, ea} * {{H{1'b0}}, eb};
      end
   end

   always_comb begin
      unique case (size)
         SZ_H:    prod = g_w[0].p;
         SZ_S:    prod = g_w[1].p;
         SZ_D:    prod = g_w[2].p;
         default: prod = '0;
      endcase
   end

   // upper halves of each lane (odd narrow elements) are deliberately dropped
   logic unused_odd;
   assign unused_odd = ^{src_a, src_b};

endmodule

// File: rtl/wvms_lane_sub.sv
`timescale 1ns/1ps
module wvms_lane_sub
   import wvms_pkg::*;
#(
   parameter int VL = 128
) (
   input  logic [VL-1:0] acc,
   input  logic [VL-1:0] prod,
   input  dec_t          dec,
   output logic [VL-1:0] res
);

   for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_w
      localparam int W = MIN_WIDE << k;
      localparam int N = VL / W;
      logic [VL-1:0] r;
      for (genvar ln = 0; ln < N; ln++) begin : g_lane
         assign r[ln*W +: W] = acc[ln*W +: W] - prod[ln*W +: W];
      end
   end

   always_comb begin
      if (dec.undef) begin
         res = acc;
      end else begin
         unique case (dec.size)
            SZ_H:    res = g_w[0].r;
            SZ_S:    res = g_w[1].r;
            SZ_D:    res = g_w[2].r;
            default: res = acc;
         endcase
      end
   end

endmodule

// File: rtl/wvms_unit.sv
`timescale 1ns/1ps
module wvms_unit
   import wvms_pkg::*;
#(
   parameter int VL = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [31:0]   insn,
   input  logic [VL-1:0] src_a,
   input  logic [VL-1:0] src_b,
   input  logic [VL-1:0] acc_in,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [VL-1:0] out_acc,
   output logic          out_undef
);

   localparam int LANE_GRAN = MAX_WIDE;

   if (VL < LANE_GRAN || (VL % LANE_GRAN) != 0) begin : g_bad_vl
      $error("wvms_unit: VL must be a positive multiple of %0d", LANE_GRAN);
   end

   // ---------------- front: decode and products ----------------
   dec_t          dec_in;
   logic [VL-1:0] prod_in;

   wvms_decode u_dec (
      .insn (insn),
      .dec  (dec_in)
   );

   wvms_prod_gen #(.VL(VL)) u_mul (
      .src_a (src_a),
      .src_b (src_b),
      .size  (dec_in.size),
      .prod  (prod_in)
   );

   // ---------------- stage 1 ----------------
   logic          advance;
   logic          s1_v;
   dec_t          s1_dec;
   logic [VL-1:0] s1_prod;
   logic [VL-1:0] s1_acc;
   logic [VL-1:0] s1_res;

   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         out_valid <= 1'b0;
      end else if (advance) begin
         s1_v      <= in_valid;
         out_valid <= s1_v;
      end
   end

   always_ff @(posedge clk) begin
      if (advance && in_valid) begin
         s1_dec  <= dec_in;
         s1_prod <= prod_in;
         s1_acc  <= acc_in;
      end
   end

   // ---------------- stage 2: subtract and hold ----------------
   wvms_lane_sub #(.VL(VL)) u_sub (
      .acc  (s1_acc),
      .prod (s1_prod),
      .dec  (s1_dec),
      .res  (s1_res)
   );

   always_ff @(posedge clk) begin
      if (advance && s1_v) begin
         out_acc   <= s1_res;
         out_undef <= s1_dec.undef;
      end
   end

endmodule

// File: rtl/wvms_unit_chk.sv
`timescale 1ns/1ps
module wvms_unit_chk #(
   parameter int VL = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic [31:0]   insn,
   input logic [VL-1:0] acc_in,
   input logic          out_valid,
   input logic          out_ready,
   input logic [VL-1:0] out_acc,
   input logic          out_undef
);

   // R7
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_acc) && $stable(out_undef)));

   // R6
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) ##1 (!out_valid || out_ready) |=> out_valid);

   // R6
   no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready, 2));

   // R3
   rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && insn[23:22] == 2'b00) ##1 (!out_valid || out_ready)
      |=> (out_valid && out_undef && out_acc == $past(acc_in, 2)));

   // R1
   legal_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && insn[31:24] == 8'b01000100 && !insn[21] &&
       insn[15:10] == 6'b010110 && insn[23:22] != 2'b00) ##1 (!out_valid || out_ready)
      |=> (out_valid && !out_undef));

   // R8
   ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

endmodule

bind wvms_unit wvms_unit_chk #(.VL(VL)) u_chk (.*);

// File: tb/wvms_unit_bench.sv
`timescale 1ns/1ps
module wvms_unit_bench;

   localparam int VL = 128;

   typedef struct {
      logic [31:0]   insn;
      logic [VL-1:0] a;
      logic [VL-1:0] b;
      logic [VL-1:0] acc;
   } stim_t;

   typedef struct {
      logic [VL-1:0] res;
      logic          undef;
      int            cyc;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic          in_ready;
   logic [31:0]   insn;
   logic [VL-1:0] src_a, src_b, acc_in;
   logic          out_valid;
   logic          out_ready;
   logic [VL-1:0] out_acc;
   logic          out_undef;

   always #2.5 clk = ~clk;

   wvms_unit #(.VL(VL)) u_wvms_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .insn(insn), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
      .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc),
      .out_undef(out_undef)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   stim_t sq[$];
   exp_t  eq[$];

   task automatic check(bit ok, string req, string what,
                        logic [VL-1:0] act, logic [VL-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [VL-1:0] rnd_vec();
      logic [VL-1:0] v;
      for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom();
      return v;
   endfunction

   function automatic logic [31:0] mk_insn(logic [1:0] sz);
      logic [4:0] zm = 5'($urandom());
      logic [4:0] zn = 5'($urandom());
      logic [4:0] zd = 5'($urandom());
      return {8'b01000100, sz, 1'b0, zm, 6'b010110, zn, zd};
   endfunction

   // keep the low half of each wide lane from a, the high half from r
   function automatic logic [VL-1:0] mix_odd(logic [VL-1:0] a, logic [VL-1:0] r, int w);
      logic [VL-1:0] m;
      for (int i = 0; i < VL; i++) m[i] = ((i % w) < (w/2));
      return (a & m) | (r & ~m);
   endfunction

   function automatic exp_t ref_calc(stim_t s, string tag);
      exp_t r;
      logic [1:0] sz = s.insn[23:22];
      bit legal = (s.insn[31:24] == 8'b01000100) && !s.insn[21] &&
                  (s.insn[15:10] == 6'b010110) && (sz != 2'b00);
      r.res = s.acc; r.undef = !legal; r.tag = tag; r.cyc = 0;
      if (legal) begin
         int w = 8 << sz;
         int h = w / 2;
         logic [63:0] mw = {64{1'b1}} >> (64 - w);
         logic [63:0] mh = {64{1'b1}} >> (64 - h);
         r.res = '0;
         for (int e = 0; e < VL/w; e++) begin
            logic [VL-1:0] sa = s.a >> (e*w);
            logic [VL-1:0] sb = s.b >> (e*w);
            logic [VL-1:0] sc = s.acc >> (e*w);
            logic [63:0] x = sa[63:0] & mh;
            logic [63:0] y = sb[63:0] & mh;
            logic [63:0] c = sc[63:0] & mw;
            logic [63:0] lane = (c - x*y) & mw;
            r.res = r.res | (VL'(lane) << (e*w));
         end
      end
      return r;
   endfunction

   function automatic stim_t mk_stim(logic [31:0] iw);
      stim_t s;
      s.insn = iw; s.a = rnd_vec(); s.b = rnd_vec(); s.acc = rnd_vec();
      return s;
   endfunction

   string cur_tag;

   task automatic run_queue(bit rnd_ready, bit gaps);
      bit            prev_v = 0, prev_r = 0, prev_u = 0;
      logic [VL-1:0] prev_d = '0;
      exp_t e;
      while (sq.size() > 0 || eq.size() > 0) begin
         @(negedge clk);
         out_ready = rnd_ready ? (($urandom() % 3) != 0) : 1'b1;
         if (sq.size() > 0 && (!gaps || ($urandom() % 2) == 1)) begin
            in_valid = 1'b1; insn = sq[0].insn;
            src_a = sq[0].a; src_b = sq[0].b; acc_in = sq[0].acc;
         end else begin
            in_valid = 1'b0; insn = $urandom();
            src_a = rnd_vec(); src_b = rnd_vec(); acc_in = rnd_vec();
         end
         #1;
         if (prev_v && !prev_r)
            // R7 held output under backpressure
            check(out_valid === 1'b1 && out_acc === prev_d && out_undef === prev_u,
                  "R7", "output changed while stalled", out_acc, prev_d);
         if (!rnd_ready && !gaps && in_valid)
            // R8 full throughput
            check(in_ready === 1'b1, "R8", "in_ready low without backpressure",
                  VL'(in_ready), VL'(1));
         if (out_valid && out_ready) begin
            if (eq.size() == 0) begin
               check(1'b0, "R6", "response without accepted input", VL'(out_valid), VL'(0));
            end else begin
               e = eq.pop_front();
               check(out_acc === e.res, e.tag, "result", out_acc, e.res);
               check(out_undef === e.undef, e.tag, "undef flag", VL'(out_undef), VL'(e.undef));
               if (!rnd_ready)
                  // R6 fixed two-cycle latency
                  check(cyc == e.cyc + 2, "R6", "latency in cycles",
                        VL'(cyc - e.cyc), VL'(2));
            end
         end
         if (in_valid && in_ready) begin
            e = ref_calc(sq.pop_front(), cur_tag);
            e.cyc = cyc;
            eq.push_back(e);
         end
         prev_v = out_valid; prev_r = out_ready; prev_d = out_acc; prev_u = out_undef;
         cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      stim_t s, s2;
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      insn = '0; src_a = '0; src_b = '0; acc_in = '0;
      repeat (3) @(negedge clk);
      #1;
      // R9 reset state
      check(out_valid === 1'b0 && in_ready === 1'b1, "R9", "state in reset",
            VL'({out_valid, in_ready}), VL'(2'b01));
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(out_valid === 1'b0 && in_ready === 1'b1, "R9", "state after reset",
            VL'({out_valid, in_ready}), VL'(2'b01));

      // R5 corners: all-ones sources into zero accumulator, zero sources into all-ones
      cur_tag = "R5";
      for (int sz = 1; sz < 4; sz++) begin
         s.insn = mk_insn(2'(sz)); s.a = '1; s.b = '1; s.acc = '0;
         sq.push_back(s);
         s.insn = mk_insn(2'(sz)); s.a = '0; s.b = '0; s.acc = '1;
         sq.push_back(s);
         s.insn = mk_insn(2'(sz)); s.a = '1; s.b = '1; s.acc = '1;
         sq.push_back(s);
      end
      run_queue(1'b0, 1'b0);

      // R2 R4 R10 random streams per size, back to back
      cur_tag = "R2 R4 R5 R10";
      for (int sz = 1; sz < 4; sz++)
         for (int i = 0; i < 40; i++) sq.push_back(mk_stim(mk_insn(2'(sz))));
      run_queue(1'b0, 1'b0);

      // R4 same even elements, different odd elements
      cur_tag = "R4";
      for (int i = 0; i < 12; i++) begin
         int sz = 1 + (i % 3);
         s = mk_stim(mk_insn(2'(sz)));
         s2 = s;
         s2.insn = mk_insn(2'(sz));
         s2.a = mix_odd(s.a, rnd_vec(), 8 << sz);
         s2.b = mix_odd(s.b, rnd_vec(), 8 << sz);
         sq.push_back(s); sq.push_back(s2);
      end
      run_queue(1'b0, 1'b1);

      // R3 reserved size
      cur_tag = "R3";
      for (int i = 0; i < 10; i++) sq.push_back(mk_stim(mk_insn(2'b00)));
      run_queue(1'b0, 1'b0);

      // R1 one fixed opcode bit flipped
      cur_tag = "R1";
      for (int i = 0; i < 30; i++) begin
         int idx = $urandom() % 15;
         int pos = (idx < 8) ? 24 + idx : ((idx == 8) ? 21 : 10 + (idx - 9));
         logic [31:0] iw = mk_insn(2'(1 + (i % 3)));
         iw[pos] = ~iw[pos];
         sq.push_back(mk_stim(iw));
      end
      run_queue(1'b0, 1'b0);

      // R7 mixed traffic under random backpressure and input gaps
      cur_tag = "R7 R5 R1";
      for (int i = 0; i < 80; i++) begin
         logic [31:0] iw = mk_insn(2'($urandom() % 4));
         if (($urandom() % 8) == 0) iw[21] = 1'b1;
         sq.push_back(mk_stim(iw));
      end
      run_queue(1'b1, 1'b1);

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule